// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block is the master side of a serial flash link for devices whose pages are not always a power of two in size. A host hands it one command at a time (read, page program or sector erase) with a 24-bit byte address that has already been translated by a neighbouring block, and a byte count. The sequencer frames the command on a mode-0 SPI bus: it sends the opcode, then the address, then streams data bytes out or collects them in. Write data is pulled from the host one byte per `wr_take` pulse. Read data is returned one byte per `rd_valid` pulse.

When reset is released, the sequencer reads the device status byte once. Bit 0 of that byte tells it whether the part runs with padded pages (264/528 bytes) or power-of-two pages (256/512 bytes), and it fixes the page and sector geometry from that bit. After every program or erase it keeps reading the status byte until the device reports ready or a host-set number of attempts has been used up. It then pulses `done`. Requests that the device cannot serve are refused without any bus traffic.

Top module: `sflash_seq`

## Requirements
- R1: While reset is applied, `spi_cs_n` is 1, `spi_sck` is 0 and `cmd_ready` is 0. After reset, the block runs exactly one status read (opcode 0xD7, no address, one byte returned). It copies bit 0 of the returned byte to `pow2_mode`, raises `init_done` and only then raises `cmd_ready`.
- R2: `page_bytes` is 264 (528 when `BIG_PAGE`=1) when `pow2_mode` is 0, and 256 (512) when it is 1. `sector_bytes` is always eight times `page_bytes`.
- R3: A read (`cmd_op`=0) sends opcode 0x03 and then the three address bytes, most significant byte first. It then clocks in `cmd_len` bytes and presents each one on `rd_data` with a one-cycle `rd_valid`, in bus order. No other read opcode is ever sent.
- R4: A page program (`cmd_op`=1) sends opcode 0x82, the three address bytes, and then the data bytes. Each data byte is the value on `wr_data` in the cycle where `wr_take` is high, and `wr_take` pulses once per data byte.
- R5: A program whose `cmd_len` exceeds `page_bytes` sends exactly `page_bytes` data bytes and sets `trunc_flag`. A program of `page_bytes` bytes or fewer sends all of its bytes and leaves `trunc_flag` at 0. The flag holds until the next accepted command.
- R6: A sector erase (`cmd_op`=2) sends opcode 0x50 and the three address bytes, and nothing else.
- R7: After a program or erase, the block issues separate status reads until one returns bit 7 set. It issues at most `poll_limit` of them (`poll_limit` ≥ 1). If none of them reports ready, `err_timeout` is set and held until the next accepted command.
- R8: A chip-erase request (`cmd_op`=3), or a read or program with `cmd_len`=0, is refused. The block pulses `cmd_reject` for one cycle, produces no bus activity and stays ready.
- R9: The bus follows mode 0: `spi_sck` idles low, `spi_mosi` changes only while `spi_sck` is low, and `spi_miso` is sampled on the rising edge. `spi_cs_n` stays low for a whole command. Between commands it stays high for at least one SPI clock period (2·`HALF` clock cycles).
- R10: `done` is a single-cycle pulse, given once for each accepted read, program or erase when it finishes (after polling, for program and erase).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 2 | 0 read, 1 program, 2 sector erase, 3 chip erase (refused) |
| cmd_addr | input | 24 | Device byte address (already translated) |
| cmd_len | input | LEN_W | Data byte count |
| cmd_ready | output | 1 | Idle and able to accept a command |
| cmd_reject | output | 1 | One-cycle pulse for a refused request |
| wr_data | input | 8 | Program data byte |
| wr_take | output | 1 | Pulse: `wr_data` consumed this cycle |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Pulse: `rd_data` valid |
| poll_limit | input | TMO_W | Maximum number of status reads after program or erase |
| done | output | 1 | Command completion pulse |
| err_timeout | output | 1 | Polling gave up; held until the next accepted command |
| trunc_flag | output | 1 | Last program was cut to one page |
| init_done | output | 1 | Start-up status read has completed |
| pow2_mode | output | 1 | Device uses power-of-two pages |
| page_bytes | output | LEN_W | Current page size |
| sector_bytes | output | LEN_W+3 | Current erase sector size |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Master data in |

## Verification
The bench models the device bit by bit at the bus pins and repeats the whole sweep once for each addressing mode. This catches a sequencer that ignores the start-up status bit and keeps the wrong page size. Program lengths of one byte, one under a page, exactly a page, one over, and far over a page are all tried. A design that is off by one in truncation sends 265 or 263 bytes, or raises the truncation flag on an exact page. Status polling is tested with the device becoming ready on the last allowed attempt and also one attempt too late. A counter with the wrong comparison either times out early or sends one extra status read. Refused requests are followed by an idle window in which the bench confirms that no bus transaction was seen and that `cmd_ready` is still high, which exposes a design that starts a chip erase or a zero-length transfer.

// File: rtl/sflash_pkg.sv
// Shared encodings for the serial flash sequencer: host command codes,
// device opcodes, status bit positions and the internal state types.
package sflash_pkg;

    typedef enum logic [1:0] {
        HOP_READ = 2'd0,
        HOP_PROG = 2'd1,
        HOP_SECT = 2'd2,
        HOP_CHIP = 2'd3
    } host_op_e;

    typedef enum logic [2:0] {
        K_STAT_INIT,
        K_READ,
        K_PROG,
        K_ERASE,
        K_POLL
    } kind_e;

    typedef enum logic [2:0] {
        S_BOOT,
        S_GAP,
        S_IDLE,
        S_LOAD,
        S_SHIFT
    } seq_state_e;

    localparam logic [7:0] OPC_READ = 8'h03;
    localparam logic [7:0] OPC_PROG = 8'h82;
    localparam logic [7:0] OPC_SECT = 8'h50;
    localparam logic [7:0] OPC_STAT = 8'hD7;

    localparam int STAT_RDY_BIT = 7;
    localparam int STAT_P2_BIT  = 0;

endpackage

// File: rtl/sflash_shifter.sv
// Mode-0 byte shifter. Sends one byte MSB first on mosi while receiving one
// byte from miso. Each SPI half period lasts HALF clock cycles. The receive
// sample is taken on the rising edge, and the next transmit bit is presented
// on the falling edge. Assumes start is raised only while busy is low.
module sflash_shifter #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       byte_done,
    output logic [7:0] rx_byte
);

    localparam int HC_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic [HC_W-1:0] hcnt_q;
    logic [2:0]      bitn_q;
    logic [7:0]      sr_q;
    logic [7:0]      rx_q;

    // Half-period timer, edge generation and bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt_q    <= '0;
            bitn_q    <= '0;
            sr_q      <= '0;
            rx_q      <= '0;
            sck       <= 1'b0;
            busy      <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy   <= 1'b1;
                    sr_q   <= tx_byte;
                    sck    <= 1'b0;
                    hcnt_q <= '0;
                    bitn_q <= '0;
                end
            end else if (hcnt_q == HC_W'(HALF - 1)) begin
                hcnt_q <= '0;
                if (!sck) begin
                    sck  <= 1'b1;
                    rx_q <= {rx_q[6:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bitn_q == 3'd7) begin
                        busy      <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        bitn_q <= bitn_q + 3'd1;
                        sr_q   <= {sr_q[6:0], 1'b0};
                    end
                end
            end else begin
                hcnt_q <= hcnt_q + HC_W'(1);
            end
        end
    end

    assign mosi    = sr_q[7];
    assign rx_byte = rx_q;

    p_sck_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(busy));

endmodule

// File: rtl/sflash_geom.sv
// Page geometry and program-length clamping. Page size comes from the device
// addressing mode; the padded size is the power-of-two size plus 1/32.
// Assumes LEN_W is wide enough to hold the padded page size.
module sflash_geom #(
    parameter int LEN_W    = 10,
    parameter bit BIG_PAGE = 1'b0
) (
    input  logic             pow2,
    input  logic [LEN_W-1:0] req_len,
    output logic [LEN_W-1:0] page_bytes,
    output logic [LEN_W+2:0] sector_bytes,
    output logic [LEN_W-1:0] eff_len,
    output logic             over
);

    localparam int P2_PAGE  = BIG_PAGE ? 512 : 256;
    localparam int PAD_PAGE = P2_PAGE + P2_PAGE / 32;

    // Select the page size and clamp the requested length to one page.
    always_comb begin
        page_bytes   = pow2 ? LEN_W'(P2_PAGE) : LEN_W'(PAD_PAGE);
        sector_bytes = {page_bytes, 3'b000};
        over         = req_len > page_bytes;
        eff_len      = over ? page_bytes : req_len;
    end

endmodule

// File: rtl/sflash_seq.sv
// Serial flash command sequencer (top). Reads the device status once after
// reset to learn its page mode, then accepts read / program / sector-erase
// commands. It frames each command on a mode-0 SPI bus and polls the status
// byte after every program or erase. Assumes the address has already been
// translated, and that poll_limit is at least 1 and stays steady while a
// command runs.
module sflash_seq
    import sflash_pkg::*;
#(
    parameter int HALF     = 2,
    parameter int LEN_W    = 10,
    parameter int TMO_W    = 8,
    parameter bit BIG_PAGE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [23:0]      cmd_addr,
    input  logic [LEN_W-1:0] cmd_len,
    output logic             cmd_ready,
    output logic             cmd_reject,
    input  logic [7:0]       wr_data,
    output logic             wr_take,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic [TMO_W-1:0] poll_limit,
    output logic             done,
    output logic             err_timeout,
    output logic             trunc_flag,
    output logic             init_done,
    output logic             pow2_mode,
    output logic [LEN_W-1:0] page_bytes,
    output logic [LEN_W+2:0] sector_bytes,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso
);

    localparam int GAP   = 2 * HALF;
    localparam int GC_W  = $clog2(GAP + 1);
    localparam int IDX_W = LEN_W + 1;

    seq_state_e       state_q;
    kind_e            kind_q;
    logic [7:0]       op_q;
    logic [23:0]      addr_q;
    logic [LEN_W-1:0] ndata_q;
    logic [IDX_W-1:0] idx_q;
    logic [GC_W-1:0]  gap_q;
    logic             pend_q;
    logic [TMO_W-1:0] poll_q;

    logic             has_addr;
    logic [IDX_W-1:0] hdr_len;
    logic [IDX_W-1:0] total;
    logic             last_byte;
    logic             in_data;
    logic [7:0]       tx_byte;
    logic             sh_start;
    logic             sh_busy;
    logic             sh_done;
    logic [7:0]       sh_rx;
    logic [LEN_W-1:0] eff_len;
    logic             len_over;
    logic             refuse;
    logic             poll_last;

    sflash_geom #(
        .LEN_W    (LEN_W),
        .BIG_PAGE (BIG_PAGE)
    ) u_geom (
        .pow2         (pow2_mode),
        .req_len      (cmd_len),
        .page_bytes   (page_bytes),
        .sector_bytes (sector_bytes),
        .eff_len      (eff_len),
        .over         (len_over)
    );

    sflash_shifter #(
        .HALF (HALF)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sh_start),
        .tx_byte   (tx_byte),
        .miso      (spi_miso),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .busy      (sh_busy),
        .byte_done (sh_done),
        .rx_byte   (sh_rx)
    );

    // Frame layout of the current transaction: header length and last byte.
    always_comb begin
        has_addr  = (kind_q == K_READ) || (kind_q == K_PROG) || (kind_q == K_ERASE);
        hdr_len   = has_addr ? IDX_W'(4) : IDX_W'(1);
        total     = hdr_len + IDX_W'(ndata_q);
        last_byte = (idx_q == total - IDX_W'(1));
        in_data   = (idx_q >= hdr_len);
    end

    // Byte to send for the current frame position.
    always_comb begin
        tx_byte = 8'hFF;
        if (idx_q == IDX_W'(0))                 tx_byte = op_q;
        else if (has_addr && idx_q == IDX_W'(1)) tx_byte = addr_q[23:16];
        else if (has_addr && idx_q == IDX_W'(2)) tx_byte = addr_q[15:8];
        else if (has_addr && idx_q == IDX_W'(3)) tx_byte = addr_q[7:0];
        else if (kind_q == K_PROG)               tx_byte = wr_data;
    end

    // Request classification and polling budget test.
    always_comb begin
        refuse    = (cmd_op == HOP_CHIP) ||
                    ((cmd_op == HOP_READ || cmd_op == HOP_PROG) && cmd_len == '0);
        poll_last = ({1'b0, poll_q} + (TMO_W + 1)'(1)) >= {1'b0, poll_limit};
        sh_start  = (state_q == S_LOAD) && !sh_busy;
        cmd_ready = (state_q == S_IDLE);
        spi_cs_n  = !((state_q == S_LOAD) || (state_q == S_SHIFT));
    end

    // Command sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_BOOT;
            kind_q      <= K_STAT_INIT;
            op_q        <= OPC_STAT;
            addr_q      <= '0;
            ndata_q     <= '0;
            idx_q       <= '0;
            gap_q       <= '0;
            pend_q      <= 1'b0;
            poll_q      <= '0;
            cmd_reject  <= 1'b0;
            wr_take     <= 1'b0;
            rd_data     <= '0;
            rd_valid    <= 1'b0;
            done        <= 1'b0;
            err_timeout <= 1'b0;
            trunc_flag  <= 1'b0;
            init_done   <= 1'b0;
            pow2_mode   <= 1'b0;
        end else begin
            cmd_reject <= 1'b0;
            wr_take    <= 1'b0;
            rd_valid   <= 1'b0;
            done       <= 1'b0;
            unique case (state_q)
                S_BOOT: begin
                    kind_q  <= K_STAT_INIT;
                    op_q    <= OPC_STAT;
                    ndata_q <= LEN_W'(1);
                    idx_q   <= '0;
                    pend_q  <= 1'b1;
                    gap_q   <= '0;
                    state_q <= S_GAP;
                end
                S_GAP: begin
                    if (gap_q == GC_W'(GAP - 1)) begin
                        gap_q   <= '0;
                        state_q <= pend_q ? S_LOAD : S_IDLE;
                    end else begin
                        gap_q <= gap_q + GC_W'(1);
                    end
                end
                S_IDLE: begin
                    if (cmd_valid) begin
                        if (refuse) begin
                            cmd_reject <= 1'b1;
                        end else begin
                            trunc_flag  <= (cmd_op == HOP_PROG) && len_over;
                            err_timeout <= 1'b0;
                            addr_q      <= cmd_addr;
                            idx_q       <= '0;
                            state_q     <= S_LOAD;
                            case (cmd_op)
                                HOP_READ: begin
                                    kind_q  <= K_READ;
                                    op_q    <= OPC_READ;
                                    ndata_q <= cmd_len;
                                end
                                HOP_PROG: begin
                                    kind_q  <= K_PROG;
                                    op_q    <= OPC_PROG;
                                    ndata_q <= eff_len;
                                end
                                default: begin
                                    kind_q  <= K_ERASE;
                                    op_q    <= OPC_SECT;
                                    ndata_q <= '0;
                                end
                            endcase
                        end
                    end
                end
                S_LOAD: begin
                    if (!sh_busy) begin
                        state_q <= S_SHIFT;
                        if (kind_q == K_PROG && in_data) wr_take <= 1'b1;
                    end
                end
                S_SHIFT: begin
                    if (sh_done) begin
                        if (kind_q == K_READ && in_data) begin
                            rd_valid <= 1'b1;
                            rd_data  <= sh_rx;
                        end
                        if (last_byte) begin
                            state_q <= S_GAP;
                            gap_q   <= '0;
                            idx_q   <= '0;
                            pend_q  <= 1'b0;
                            case (kind_q)
                                K_STAT_INIT: begin
                                    pow2_mode <= sh_rx[STAT_P2_BIT];
                                    init_done <= 1'b1;
                                end
                                K_READ: done <= 1'b1;
                                K_PROG, K_ERASE: begin
                                    kind_q  <= K_POLL;
                                    op_q    <= OPC_STAT;
                                    ndata_q <= LEN_W'(1);
                                    poll_q  <= '0;
                                    pend_q  <= 1'b1;
                                end
                                default: begin
                                    if (sh_rx[STAT_RDY_BIT]) begin
                                        done <= 1'b1;
                                    end else if (poll_last) begin
                                        err_timeout <= 1'b1;
                                        done        <= 1'b1;
                                    end else begin
                                        poll_q <= poll_q + TMO_W'(1);
                                        pend_q <= 1'b1;
                                    end
                                end
                            endcase
                        end else begin
                            idx_q   <= idx_q + IDX_W'(1);
                            state_q <= S_LOAD;
                        end
                    end
                end
                default: state_q <= S_BOOT;
            endcase
        end
    end

    // Checker-side count of clock cycles with chip select high.
    logic [GC_W-1:0] hi_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              hi_cnt_q <= '0;
        else if (!spi_cs_n)      hi_cnt_q <= '0;
        else if (hi_cnt_q != GC_W'(GAP)) hi_cnt_q <= hi_cnt_q + GC_W'(1);
    end

    p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> hi_cnt_q == GC_W'(GAP));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (spi_cs_n && !spi_sck));

    p_opcode_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_start && idx_q == IDX_W'(0)) |->
        (tx_byte == OPC_READ || tx_byte == OPC_PROG ||
         tx_byte == OPC_SECT || tx_byte == OPC_STAT));

    p_prog_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == K_PROG && !spi_cs_n) |-> ndata_q <= page_bytes);

    p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == K_POLL && state_q == S_SHIFT) |->
        ({1'b0, poll_q} < {1'b0, poll_limit}));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_rdv_read_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> kind_q == K_READ);

    p_ready_after_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> init_done);

endmodule

// File: tb/sflash_seq_bench.sv
// Bench: a bit-level device model at the SPI pins plus a sweep over both
// page modes, program lengths around the page boundary, read patterns,
// polling limits and refused requests.
module sflash_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int LEN_W      = 10;
    localparam int TMO_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_op = '0;
    logic [23:0]      cmd_addr = '0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic             cmd_ready, cmd_reject;
    logic [7:0]       wr_data = '0;
    logic             wr_take;
    logic [7:0]       rd_data;
    logic             rd_valid;
    logic [TMO_W-1:0] poll_limit = TMO_W'(4);
    logic             done, err_timeout, trunc_flag, init_done, pow2_mode;
    logic [LEN_W-1:0] page_bytes;
    logic [LEN_W+2:0] sector_bytes;
    logic             spi_cs_n, spi_sck, spi_mosi;
    logic             spi_miso = 1'b0;

    sflash_seq #(.HALF(HALF), .LEN_W(LEN_W), .TMO_W(TMO_W), .BIG_PAGE(1'b0)) u_sflash_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_ready(cmd_ready),
        .cmd_reject(cmd_reject), .wr_data(wr_data), .wr_take(wr_take),
        .rd_data(rd_data), .rd_valid(rd_valid), .poll_limit(poll_limit),
        .done(done), .err_timeout(err_timeout), .trunc_flag(trunc_flag),
        .init_done(init_done), .pow2_mode(pow2_mode), .page_bytes(page_bytes),
        .sector_bytes(sector_bytes), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rdat(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    function automatic logic [7:0] pdat(input int k);
        return 8'((k * 7 + 3) & 255);
    endfunction

    // ---------------- device model ----------------
    bit          m_pow2 = 1'b0;
    int          busy_cfg = 0;
    int          busy_left = 0;
    int          bitc = 0;
    bit          in_tx = 1'b0;
    logic [7:0]  cap [0:1099];
    int          n_trans = 0;
    int          polls_seen = 0;
    int          frame_err = 0;
    logic [7:0]  last_op = '0;
    int          last_nb = 0;
    logic [23:0] last_addr = '0;
    logic [7:0]  pbuf [0:1099];
    int          pb_n = 0;
    logic [23:0] pb_addr = '0;

    function automatic logic resp_bit(input int c);
        int          b;
        logic [7:0]  v;
        logic [23:0] a;
        b = c / 8;
        v = 8'h00;
        if (b >= 1 && cap[0] == 8'hD7) v = {busy_left == 0, 6'b0, m_pow2};
        else if (b >= 4 && cap[0] == 8'h03) begin
            a = {cap[1], cap[2], cap[3]};
            v = rdat(a + 24'(b - 4));
        end
        return v[7 - (c % 8)];
    endfunction

    always @(negedge spi_cs_n) begin
        bitc     = 0;
        in_tx    = 1'b1;
        spi_miso = 1'b0;
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            cap[bitc / 8][7 - (bitc % 8)] = spi_mosi;
            bitc++;
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n) spi_miso = resp_bit(bitc);
    end

    always @(posedge spi_cs_n) begin
        if (in_tx) begin
            in_tx = 1'b0;
            n_trans++;
            if (bitc % 8 != 0) frame_err++;
            last_op   = cap[0];
            last_nb   = bitc / 8;
            last_addr = {cap[1], cap[2], cap[3]};
            if (cap[0] == 8'h82) begin
                pb_n    = last_nb - 4;
                pb_addr = last_addr;
                for (int i = 0; i < pb_n; i++) pbuf[i] = cap[i + 4];
                busy_left  = busy_cfg;
                polls_seen = 0;
            end else if (cap[0] == 8'h50) begin
                busy_left  = busy_cfg;
                polls_seen = 0;
            end else if (cap[0] == 8'hD7) begin
                polls_seen++;
                if (busy_left > 0) busy_left--;
            end
        end
    end

    // ---------------- observers ----------------
    logic [7:0] rbuf [0:1099];
    int rn = 0;
    int hc = 0;
    int min_gap = 1000000;
    int sck_viol = 0;
    int done_cnt = 0;
    int done_dbl = 0;
    bit done_prev = 1'b0;

    always @(negedge clk) begin
        if (rd_valid) begin
            rbuf[rn] = rd_data;
            rn++;
        end
        if (rst_n) begin
            if (spi_cs_n) hc++;
            else begin
                if (hc > 0 && hc < min_gap) min_gap = hc;
                hc = 0;
            end
            if (spi_cs_n && spi_sck) sck_viol++;
            if (done) done_cnt++;
            if (done && done_prev) done_dbl++;
            done_prev = done;
        end
    end

    // Program data source: next byte after every wr_take.
    int wk = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (wr_take) begin
                wk++;
                wr_data = pdat(wk);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    bit got_rej;
    bit got_done;
    int exp_done = 0;

    task automatic send(input logic [1:0] op, input logic [23:0] a, input int len);
        int guard = 0;
        @(negedge clk);
        while (!cmd_ready && guard < 50000) begin
            @(negedge clk);
            guard++;
        end
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = a;
        cmd_len   = LEN_W'(len);
        @(negedge clk);
        got_rej   = cmd_reject;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        got_done = 1'b0;
        while (!done && guard < 40000) begin
            @(negedge clk);
            guard++;
        end
        got_done = done;
        @(negedge clk);
    endtask

    task automatic do_reset(input bit mode);
        m_pow2    = mode;
        busy_left = 0;
        rst_n     = 1'b0;
        repeat (4) @(negedge clk);
        chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1", "bus idle in reset",
            int'(spi_sck), 0);
        chk(cmd_ready === 1'b0, "R1", "not ready in reset", int'(cmd_ready), 0);
        n_trans = 0;
        rst_n   = 1'b1;
    endtask

    task automatic run_read(input logic [23:0] a, input int len);
        int bad = 0;
        rn = 0;
        send(2'd0, a, len);
        wait_done();
        exp_done++;
        chk(got_done, "R10", "read done", int'(got_done), 1);
        chk(rn == len, "R3", "read byte count", rn, len);
        for (int i = 0; i < len; i++) if (rbuf[i] !== rdat(a + 24'(i))) bad++;
        chk(bad == 0, "R3", "read data mismatches", bad, 0);
        chk(last_op == 8'h03 && last_addr == a && last_nb == 4 + len, "R3",
            "read frame opcode/addr/bytes", int'(last_op), 3);
    endtask

    task automatic run_prog(input logic [23:0] a, input int len, input int page);
        int bad = 0;
        int exp_n;
        exp_n    = (len > page) ? page : len;
        busy_cfg = 2;
        wk       = 0;
        wr_data  = pdat(0);
        send(2'd1, a, len);
        wait_done();
        exp_done++;
        chk(got_done, "R10", "program done", int'(got_done), 1);
        chk(pb_n == exp_n, "R5", "program bytes on bus", pb_n, exp_n);
        chk(pb_addr == a, "R4", "program address", int'(pb_addr), int'(a));
        for (int i = 0; i < exp_n; i++) if (pbuf[i] !== pdat(i)) bad++;
        chk(bad == 0, "R4", "program data mismatches", bad, 0);
        chk(wk == exp_n, "R4", "wr_take pulses", wk, exp_n);
        chk(trunc_flag == (len > page), "R5", "trunc_flag", int'(trunc_flag),
            int'(len > page));
        chk(polls_seen == 3 && !err_timeout, "R7", "polls after program",
            polls_seen, 3);
    endtask

    task automatic run_erase(input logic [23:0] a, input int busy, input int lim);
        int exp_polls;
        bit exp_to;
        busy_cfg   = busy;
        poll_limit = TMO_W'(lim);
        exp_to     = (busy + 1 > lim);
        exp_polls  = exp_to ? lim : busy + 1;
        send(2'd2, a, 0);
        wait_done();
        exp_done++;
        chk(got_done, "R10", "erase done", int'(got_done), 1);
        chk(polls_seen == exp_polls, "R7", "status reads after erase",
            polls_seen, exp_polls);
        chk(err_timeout == exp_to, "R7", "err_timeout", int'(err_timeout),
            int'(exp_to));
        poll_limit = TMO_W'(4);
    endtask

    task automatic run_refuse(input logic [1:0] op, input int len);
        int t0;
        t0 = n_trans;
        send(op, 24'h000100, len);
        chk(got_rej, "R8", "reject pulse", int'(got_rej), 1);
        repeat (100) @(negedge clk);
        chk(n_trans == t0 && cmd_ready, "R8", "no bus traffic after refusal",
            n_trans - t0, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (195000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // ---------------- main sweep ----------------
    initial begin
        int page;
        int guard;
        logic [23:0] addrs [0:2];
        int          lens  [0:2];
        addrs[0] = 24'h000000; addrs[1] = 24'h012345; addrs[2] = 24'hFFFFF0;
        lens[0]  = 1;          lens[1]  = 5;          lens[2]  = 17;

        for (int mode = 0; mode < 2; mode++) begin
            do_reset(mode[0]);
            guard = 0;
            while (!cmd_ready && guard < 2000) begin
                @(negedge clk);
                guard++;
            end
            page = mode ? 256 : 264;
            // R1: one start-up status read, then mode latched
            chk(n_trans == 1 && last_op == 8'hD7 && last_nb == 2, "R1",
                "start-up status frame bytes", last_nb, 2);
            chk(init_done && pow2_mode == mode[0], "R1", "pow2_mode",
                int'(pow2_mode), mode);
            chk(page_bytes == LEN_W'(page), "R2", "page_bytes", int'(page_bytes), page);
            chk(sector_bytes == (LEN_W + 3)'(8 * page), "R2", "sector_bytes",
                int'(sector_bytes), 8 * page);

            for (int ai = 0; ai < 3; ai++)
                for (int li = 0; li < 3; li++)
                    run_read(addrs[ai], lens[li]);

            run_prog(24'h000200, 1, page);
            run_prog(24'h010000, page - 1, page);
            run_prog(24'h020000, page, page);
            run_prog(24'h030000, page + 1, page);
            run_prog(24'h040000, 600, page);

            run_erase(24'h002100, 0, 4);
            chk(last_op == 8'hD7, "R6", "erase followed by status", int'(last_op), 215);
            run_erase(24'h004200, 3, 4);
            run_erase(24'h006300, 4, 4);
            run_read(24'h000010, 2);
            chk(!err_timeout && !trunc_flag, "R7", "flags cleared by next command",
                int'(err_timeout), 0);

            run_refuse(2'd3, 5);
            run_refuse(2'd0, 0);
            run_refuse(2'd1, 0);
        end

        // R6: a lone erase frame carries opcode and address only
        busy_cfg = 0;
        send(2'd2, 24'hABCDE0, 0);
        @(posedge spi_cs_n);
        @(negedge clk);
        chk(last_op == 8'h50 && last_nb == 4 && last_addr == 24'hABCDE0, "R6",
            "erase frame bytes", last_nb, 4);
        wait_done();
        exp_done++;

        chk(min_gap >= 2 * HALF, "R9", "min cs high cycles", min_gap, 2 * HALF);
        chk(sck_viol == 0, "R9", "sck high with cs released", sck_viol, 0);
        chk(frame_err == 0, "R9", "partial-byte frames", frame_err, 0);
        chk(done_cnt == exp_done && done_dbl == 0, "R10", "done pulse count",
            done_cnt, exp_done);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule